// File: doc/BRIEF.md
# Dithered Split-Field PWM Generator

This block produces pulse-width-modulated outputs for a small set of independent channels, two by default. It does not own its time base: an 8-bit free-running count, shared with a timer prescaler elsewhere in the chip, arrives as an input. Each channel has an 8-bit duty input and an enable. A single mode input chooses how the duty value is split between a coarse part and a fine part.

A full PWM period lasts 256 counts. It is divided into equal modulation slices: four slices of 64 counts, or two slices of 128 counts. The coarse part of the duty value sets the high time that every slice gets. The fine part says how many of the leading slices get one extra high count. Over a full period the output is therefore high for exactly the duty value in counts, but the low-order bits appear as single-count dither spread over the period instead of as one long pulse. This raises the ripple frequency seen by a downstream filter.

Duty and mode are sampled only when the count is zero, so a period never mixes two settings. The outputs are registered.

Top module: `dpwm_pair`

## Requirements
- R1: While reset is asserted, and in the first clock after it, every output is low.
- R2: With mode input 0 (quarter split), the coarse value is duty bits 7..2 and the fine value is duty bits 1..0. Count bits 7..6 give the slice index 0..3, and count bits 5..0 give the position inside the 64-count slice.
- R3: Inside slice i, the output is high at positions below L, where L = coarse + 1 if i < fine and L = coarse otherwise. The high time therefore starts at position 0 of the slice. A nonzero duty value gives a high output at count 0.
- R4: With mode input 1 (half split), the coarse value is duty bits 7..1 and the fine value is duty bit 0. Count bit 7 is the slice index 0..1, and count bits 6..0 give the position inside the 128-count slice.
- R5: A channel's duty value is captured when the count equals 0 and used for the whole period that follows. Duty changes made at any other count have no effect until the next count of 0.
- R6: The mode input is captured at count 0 in the same way. Mode changes made during a period take effect only at the next count of 0.
- R7: A duty value of 0 gives a constant low output for the whole period.
- R8: A channel whose enable is low drives a low output from the clock edge at which the low enable is seen. Each channel's enable and duty affect only that channel.
- R9: The output after a rising edge reflects the count value present at that edge. There is one register of latency.
- R10: In both modes, the number of high counts over one full period equals the duty value. The output is low at count 255 for every duty value, so a duty of 255 is high for 255 of 256 counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_cnt_i | input | 8 | Shared free-running prescaler count |
| split_sel_i | input | 1 | 0: quarter split (6 coarse + 2 fine bits), 1: half split (7 + 1) |
| chan_en_i | input | N_CH | Per-channel enable |
| duty_i | input | 8*N_CH | Duty values, channel c at bits 8c+7..8c |
| pwm_o | output | N_CH | PWM outputs |

## Verification
The checker assumes that the shared count moves by one per clock, wrapping from 255 to 0, or holds its value. Under that assumption count 0 marks a period boundary and count 255 is the last count of a slice. The properties that capture at count 0 and stay low at count 255 depend on it. The bench drives the count itself and advances it by exactly one at each falling edge. It changes duty, mode and enable only at falling edges, at chosen counts within the period, so every input is stable around the rising edge that samples it.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

  localparam int DUTY_W  = 8;
  localparam int CNT_W   = 8;
  localparam int SUB_W   = 2;
  localparam int POS_W   = CNT_W - 1;

  typedef enum logic {
    SPLIT_QUARTER = 1'b0,
    SPLIT_HALF    = 1'b1
  } split_e;

  // coarse portion of the duty word for a given split
  function automatic logic [POS_W-1:0] coarse_of(input logic [DUTY_W-1:0] d,
                                                  input split_e m);
    if (m == SPLIT_HALF) coarse_of = d[DUTY_W-1:1];
    else                 coarse_of = {1'b0, d[DUTY_W-1:2]};
  endfunction

  // fine (dither) portion of the duty word
  function automatic logic [SUB_W-1:0] fine_of(input logic [DUTY_W-1:0] d,
                                               input split_e m);
    if (m == SPLIT_HALF) fine_of = {1'b0, d[0]};
    else                 fine_of = d[1:0];
  endfunction

  // slice index taken from the shared count
  function automatic logic [SUB_W-1:0] slice_of(input logic [CNT_W-1:0] c,
                                                input split_e m);
    if (m == SPLIT_HALF) slice_of = {1'b0, c[CNT_W-1]};
    else                 slice_of = c[CNT_W-1:CNT_W-2];
  endfunction

  // position inside the slice
  function automatic logic [POS_W-1:0] pos_of(input logic [CNT_W-1:0] c,
                                              input split_e m);
    if (m == SPLIT_HALF) pos_of = c[POS_W-1:0];
    else                 pos_of = {1'b0, c[CNT_W-3:0]};
  endfunction

  // high length of one slice: coarse, plus one while slice < fine
  function automatic logic [POS_W:0] slice_len(input logic [POS_W-1:0] crs,
                                               input logic [SUB_W-1:0] fin,
                                               input logic [SUB_W-1:0] sl);
    slice_len = {1'b0, crs} + ((sl < fin) ? {{POS_W{1'b0}}, 1'b1}
                                          : {(POS_W+1){1'b0}});
  endfunction

endpackage

// File: rtl/dpwm_phase.sv
module dpwm_phase
  import dpwm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic                 split_i,
  output logic                 cyc_start_o,
  output split_e               mode_eff_o,
  output split_e               mode_q_o,
  output logic [SUB_W-1:0]     slice_o,
  output logic [POS_W-1:0]     pos_o
);

  split_e mode_q;

  assign cyc_start_o = (cnt_i == '0);
  assign mode_eff_o  = cyc_start_o ? split_e'(split_i) : mode_q;
  assign mode_q_o    = mode_q;
  assign slice_o     = slice_of(cnt_i, mode_eff_o);
  assign pos_o       = pos_of(cnt_i, mode_eff_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mode_q <= SPLIT_QUARTER;
    else if (cyc_start_o) mode_q <= split_e'(split_i);
  end

endmodule

// File: rtl/dpwm_slot.sv
module dpwm_slot
  import dpwm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cyc_start_i,
  input  split_e               mode_i,
  input  logic [SUB_W-1:0]     slice_i,
  input  logic [POS_W-1:0]     pos_i,
  input  logic [DUTY_W-1:0]    duty_i,
  input  logic                 en_i,
  output logic [DUTY_W-1:0]    act_duty_o,
  output logic [DUTY_W-1:0]    hold_o,
  output logic                 pwm_o
);

  logic [DUTY_W-1:0] hold_q;
  logic [POS_W-1:0]  crs;
  logic [SUB_W-1:0]  fin;
  logic [POS_W:0]    len;
  logic              hi;

  assign act_duty_o = cyc_start_i ? duty_i : hold_q;
  assign hold_o     = hold_q;
  assign crs        = coarse_of(act_duty_o, mode_i);
  assign fin        = fine_of(act_duty_o, mode_i);
  assign len        = slice_len(crs, fin, slice_i);
  assign hi         = ({1'b0, pos_i} < len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      pwm_o  <= 1'b0;
    end else begin
      if (cyc_start_i) hold_q <= duty_i;
      pwm_o <= en_i & hi;
    end
  end

endmodule

// File: rtl/dpwm_pair.sv
module dpwm_pair
  import dpwm_pkg::*;
#(
  parameter int N_CH = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CNT_W-1:0]         tick_cnt_i,
  input  logic                     split_sel_i,
  input  logic [N_CH-1:0]          chan_en_i,
  input  logic [N_CH*DUTY_W-1:0]   duty_i,
  output logic [N_CH-1:0]          pwm_o
);

  logic                    cyc_start;
  split_e                  mode_eff;
  split_e                  mode_q;
  logic [SUB_W-1:0]        slice_idx;
  logic [POS_W-1:0]        slice_pos;
  logic [N_CH*DUTY_W-1:0]  act_duty;
  logic [N_CH*DUTY_W-1:0]  hold_duty;

  dpwm_phase u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_i       (tick_cnt_i),
    .split_i     (split_sel_i),
    .cyc_start_o (cyc_start),
    .mode_eff_o  (mode_eff),
    .mode_q_o    (mode_q),
    .slice_o     (slice_idx),
    .pos_o       (slice_pos)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dpwm_slot u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .cyc_start_i (cyc_start),
      .mode_i      (mode_eff),
      .slice_i     (slice_idx),
      .pos_i       (slice_pos),
      .duty_i      (duty_i[c*DUTY_W +: DUTY_W]),
      .en_i        (chan_en_i[c]),
      .act_duty_o  (act_duty[c*DUTY_W +: DUTY_W]),
      .hold_o      (hold_duty[c*DUTY_W +: DUTY_W]),
      .pwm_o       (pwm_o[c])
    );
  end

endmodule

// File: rtl/dpwm_pair_chk.sv
module dpwm_pair_chk
  import dpwm_pkg::*;
#(
  parameter int N_CH = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CNT_W-1:0]         tick_cnt_i,
  input  logic                     split_sel_i,
  input  logic [N_CH-1:0]          chan_en_i,
  input  logic [N_CH*DUTY_W-1:0]   duty_i,
  input  logic [N_CH-1:0]          pwm_o,
  input  logic                     cyc_start,
  input  logic                     mode_q,
  input  logic [N_CH*DUTY_W-1:0]   act_duty,
  input  logic [N_CH*DUTY_W-1:0]   hold_duty
);

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start |=> $stable(mode_q));  // R6
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> mode_q == $past(split_sel_i));  // R6

  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    AST_DIS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en_i[c] |=> !pwm_o[c]);  // R8
    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      act_duty[c*DUTY_W +: DUTY_W] == '0 |=> !pwm_o[c]);  // R7
    AST_HOLD_MID: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_start |=> $stable(hold_duty[c*DUTY_W +: DUTY_W]));  // R5
    AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_start |=> hold_duty[c*DUTY_W +: DUTY_W] == $past(duty_i[c*DUTY_W +: DUTY_W]));  // R5
    AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en_i[c] && tick_cnt_i == '0 && duty_i[c*DUTY_W +: DUTY_W] != '0) |=> pwm_o[c]);  // R3
    AST_LAST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      tick_cnt_i == '1 |=> !pwm_o[c]);  // R10
  end

endmodule

bind dpwm_pair dpwm_pair_chk #(.N_CH(N_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_cnt_i  (tick_cnt_i),
  .split_sel_i (split_sel_i),
  .chan_en_i   (chan_en_i),
  .duty_i      (duty_i),
  .pwm_o       (pwm_o),
  .cyc_start   (cyc_start),
  .mode_q      (mode_q),
  .act_duty    (act_duty),
  .hold_duty   (hold_duty)
);

// File: tb/tb_dpwm_pair.sv
module tb_dpwm_pair;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cnt = 8'd0;
  logic        split = 1'b0;
  logic [1:0]  en = 2'b00;
  logic [15:0] duty = 16'd0;
  logic [1:0]  pwm;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int mdl_duty [2];
  int mdl_mode;
  int hi_sum [2];

  always #4 clk = ~clk;

  dpwm_pair dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_cnt_i  (cnt),
    .split_sel_i (split),
    .chan_en_i   (en),
    .duty_i      (duty),
    .pwm_o       (pwm)
  );

  // expected level: high counts per slice = duty / slices-per-period share
  function automatic int want(int d, int m, int c);
    int nslice = (m == 1) ? 2 : 4;
    int span   = 256 / nslice;
    int s      = c / span;
    int p      = c % span;
    int len    = d / nslice + (((d % nslice) > s) ? 1 : 0);
    return (p < len) ? 1 : 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (t=%0t cnt=%0d)", tag, act, exp, $time, cnt);
    end
  endtask

  // one count: outputs reflect cnt latched at the last rising edge
  task automatic tick(string tag);
    @(negedge clk);
    if (cnt == 8'd0) begin
      mdl_duty[0] = duty[7:0];
      mdl_duty[1] = duty[15:8];
      mdl_mode    = split;
    end
    for (int c = 0; c < 2; c++) begin
      int e = en[c] ? want(mdl_duty[c], mdl_mode, cnt) : 0;
      check(tag, pwm[c], e);
      hi_sum[c] += pwm[c];
    end
    cnt = cnt + 8'd1;
  endtask

  task automatic period(string tag);
    hi_sum[0] = 0;
    hi_sum[1] = 0;
    for (int k = 0; k < 256; k++) tick(tag);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset", pwm, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", pwm, 0);
    cnt = 8'd0;
  endtask

  task automatic t_quarter();
    int vals [4] = '{8'h9D, 8'h02, 8'h41, 8'hC3};
    en = 2'b11;
    split = 1'b0;
    for (int v = 0; v < 4; v += 2) begin
      duty = {vals[v+1][7:0], vals[v][7:0]};
      period("R2 R3 R9 quarter");
      period("R2 R3 R9 quarter");
      check("R10 quarter sum ch0", hi_sum[0], vals[v]);
      check("R10 quarter sum ch1", hi_sum[1], vals[v+1]);
    end
  endtask

  task automatic t_half();
    split = 1'b1;
    duty = {8'h81, 8'h37};
    period("R4 half");
    period("R4 half");
    check("R4 R10 half sum ch0", hi_sum[0], 8'h37);
    check("R4 R10 half sum ch1", hi_sum[1], 8'h81);
  endtask

  task automatic t_midchange();
    split = 1'b0;
    duty = {8'h10, 8'h21};
    period("R5 settle");
    hi_sum[0] = 0;
    hi_sum[1] = 0;
    for (int k = 0; k < 256; k++) begin
      tick("R5 R6 mid change");
      if (k == 40) begin
        duty = {8'hF0, 8'h05};
        split = 1'b1;
      end
    end
    check("R5 old duty kept ch0", hi_sum[0], 8'h21);
    check("R5 old duty kept ch1", hi_sum[1], 8'h10);
    period("R5 R6 new period");
    check("R5 R6 new duty ch0", hi_sum[0], 8'h05);
    check("R5 R6 new duty ch1", hi_sum[1], 8'hF0);
  endtask

  task automatic t_zero_full();
    split = 1'b0;
    duty = {8'hFF, 8'h00};
    period("R7 R10 extremes");
    period("R7 R10 extremes");
    check("R7 zero sum", hi_sum[0], 0);
    check("R10 full sum", hi_sum[1], 255);
    split = 1'b1;
    duty = {8'h00, 8'hFF};
    period("R7 R10 half extremes");
    period("R7 R10 half extremes");
    check("R10 half full sum", hi_sum[0], 255);
    check("R7 half zero sum", hi_sum[1], 0);
  endtask

  task automatic t_disable();
    split = 1'b0;
    duty = {8'hA0, 8'hA0};
    period("R8 settle");
    for (int k = 0; k < 256; k++) begin
      tick("R8 enable");
      if (k == 10) en = 2'b10;
    end
    period("R8 ch0 off");
    check("R8 disabled sum ch0", hi_sum[0], 0);
    check("R8 neighbour sum ch1", hi_sum[1], 8'hA0);
    en = 2'b11;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    mdl_duty[0] = 0;
    mdl_duty[1] = 0;
    mdl_mode = 0;
    t_reset();
    t_quarter();
    t_half();
    t_midchange();
    t_zero_full();
    t_disable();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule